// File: doc/BRIEF.md
# Dynamic Priority Arbiter with Selectable Tie-Break

This block grants one of `N_REQ` requestors access to a shared resource. Each requestor brings its own priority level on a packed input vector, and that level may change on any cycle. The decision is made in two steps. The first step finds the highest level held by any active requestor. The second step chooses among the requestors at that level, either by lowest index or by rotation from the last winner. A build-time parameter picks the tie-break.

The decision is held in a registered grant. A new decision is latched on the clock edge when the current grant is consumed (`ack_i` high while `valid_o` is high) or when no grant is held. While a grant is held and not yet consumed, the grant and valid outputs do not change. A typical use places one requestor per FIFO, with `req_i` driven from "not empty", a one-hot grant driving the extract lines, and `ack_i` driven from downstream flow control. The grant can also be produced as a binary index or as a thermometer code. Reset can be asynchronous or synchronous, selected by a parameter.

Top module: `dprio_arb`

## Requirements
- R1: While reset is active, and on the first cycle after it, `valid_o` is low and `grant_o` is all zeros. Reset sets the rotation pointer so that the first rotating search starts at index 0. Reset also applies again in mid-run.
- R2: A new decision is latched on any clock edge where `valid_o` is low or `ack_i` is high. From the next cycle on, `valid_o` equals the OR of `req_i` sampled at that edge.
- R3: Requestor i has priority level `prio_i[i*PRIO_W +: PRIO_W]`, and a larger value means more urgent. A latched grant always goes to an active requestor whose level is the maximum over all active requestors.
- R4: With the fixed tie-break, the lowest index wins among the active requestors at the winning level.
- R5: With the rotating tie-break, the winner is the first active requestor at the winning level found when searching upward from the index just after the last latched winner, wrapping from N_REQ-1 to 0.
- R6: While `valid_o` is high and `ack_i` is low, `grant_o` and `valid_o` keep their values, whatever `req_i` and `prio_i` do. The rotation pointer moves only when a grant with at least one active request is latched.
- R7: A change of `prio_i` takes effect at the next latch edge, without any reset or other set-up.
- R8: For winner index k, the one-hot encoding sets bit k only. The binary encoding outputs k, with width ceil(log2 N_REQ). The thermometer encoding sets bits 0 through k.
- R9: If no request is active at a latch edge, `valid_o` goes low and `grant_o` is all zeros in every encoding.
- R10: The parameter `ASYNC_RST` (1 = asynchronous, 0 = synchronous) selects the reset style, and both styles clear the same state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | N_REQ | Request per requestor |
| prio_i | input | N_REQ*PRIO_W | Packed priority levels, requestor i at bits [i*PRIO_W +: PRIO_W] |
| ack_i | input | 1 | Current grant consumed |
| grant_o | output | N_REQ, or ceil(log2 N_REQ) when binary | Registered grant in the chosen encoding |
| valid_o | output | 1 | Grant is meaningful |

## Verification
A corrupted rotation pointer would not alter any output until a tie at the winning level comes up at a latch edge. At that point the wrong requestor's bit appears one cycle later. An exhaustive sweep with `ack_i` held high therefore exposes it within a few cycles. A wrong level-select or tie-break result is visible in the grant on the cycle right after the latch edge. A broken hold path shows as a grant that moves while `ack_i` is low.

// File: rtl/dprio_pkg.sv
package dprio_pkg;

  typedef enum logic [1:0] {
    GRANT_ONEHOT = 2'd0,
    GRANT_BINARY = 2'd1,
    GRANT_THERMO = 2'd2
  } grant_fmt_e;

  typedef enum logic {
    TIE_LOWEST_ID = 1'b0,
    TIE_ROTATE    = 1'b1
  } tie_mode_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int grant_width(input grant_fmt_e fmt, input int n);
    return (fmt == GRANT_BINARY) ? idx_width(n) : n;
  endfunction

endpackage

// File: rtl/dprio_level_sel.sv
// Stage one: find the most urgent level among active requestors and
// flag every active requestor sitting at that level.
module dprio_level_sel #(
  parameter int N_REQ  = 4,
  parameter int PRIO_W = 2
) (
  input  logic [N_REQ-1:0]        req_i,
  input  logic [N_REQ*PRIO_W-1:0] prio_i,
  output logic [N_REQ-1:0]        cand_o,
  output logic                    any_o
);

  logic [PRIO_W-1:0] top_lvl;

  always_comb begin
    top_lvl = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        if (prio_i[i*PRIO_W +: PRIO_W] > top_lvl) begin
          top_lvl = prio_i[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_cand
    assign cand_o[g] = req_i[g] && (prio_i[g*PRIO_W +: PRIO_W] == top_lvl);
  end

endmodule

// File: rtl/dprio_tie_break.sv
// Stage two: pick one candidate, either lowest index or rotating from
// the index just after the pointer.
module dprio_tie_break #(
  parameter int                   N_REQ    = 4,
  parameter dprio_pkg::tie_mode_e TIE_MODE = dprio_pkg::TIE_ROTATE,
  localparam int                  IDX_W    = dprio_pkg::idx_width(N_REQ)
) (
  input  logic [N_REQ-1:0] cand_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [N_REQ-1:0] win_oh_o
);

  function automatic logic [N_REQ-1:0] lowest_set(input logic [N_REQ-1:0] v);
    return v & (~v + {{(N_REQ-1){1'b0}}, 1'b1});
  endfunction

  if (TIE_MODE == dprio_pkg::TIE_ROTATE) begin : g_rotate
    logic [N_REQ-1:0] above_ptr;
    logic [N_REQ-1:0] upper_cand;

    for (genvar g = 0; g < N_REQ; g++) begin : g_above
      assign above_ptr[g] = (IDX_W'(g) > ptr_i);
    end

    assign upper_cand = cand_i & above_ptr;

    always_comb begin
      if (|upper_cand) begin
        win_oh_o = lowest_set(upper_cand);
      end else begin
        win_oh_o = lowest_set(cand_i);
      end
    end
  end else begin : g_lowest
    logic unused_ptr;
    assign unused_ptr = ^ptr_i;
    assign win_oh_o   = lowest_set(cand_i);
  end

endmodule

// File: rtl/dprio_grant_enc.sv
// Converts the held one-hot grant to the output encoding.
module dprio_grant_enc #(
  parameter int                    N_REQ = 4,
  parameter dprio_pkg::grant_fmt_e FMT   = dprio_pkg::GRANT_ONEHOT,
  localparam int                   OUT_W = dprio_pkg::grant_width(FMT, N_REQ)
) (
  input  logic [N_REQ-1:0] oh_i,
  output logic [OUT_W-1:0] code_o
);

  if (FMT == dprio_pkg::GRANT_BINARY) begin : g_bin
    always_comb begin
      code_o = '0;
      for (int i = 0; i < N_REQ; i++) begin
        if (oh_i[i]) begin
          code_o = code_o | OUT_W'(i);
        end
      end
    end
  end else if (FMT == dprio_pkg::GRANT_THERMO) begin : g_thermo
    for (genvar g = 0; g < N_REQ; g++) begin : g_bit
      assign code_o[g] = |(oh_i >> g);
    end
  end else begin : g_onehot
    assign code_o = oh_i;
  end

endmodule

// File: rtl/dprio_arb.sv
module dprio_arb #(
  parameter int                    N_REQ     = 4,
  parameter int                    PRIO_W    = 2,
  parameter dprio_pkg::tie_mode_e  TIE_MODE  = dprio_pkg::TIE_ROTATE,
  parameter dprio_pkg::grant_fmt_e GRANT_FMT = dprio_pkg::GRANT_ONEHOT,
  parameter bit                    ASYNC_RST = 1'b1
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic [N_REQ-1:0]                                    req_i,
  input  logic [N_REQ*PRIO_W-1:0]                             prio_i,
  input  logic                                                ack_i,
  output logic [dprio_pkg::grant_width(GRANT_FMT, N_REQ)-1:0] grant_o,
  output logic                                                valid_o
);

  localparam int IDX_W = dprio_pkg::idx_width(N_REQ);
  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(N_REQ - 1);

  logic [N_REQ-1:0] cand;
  logic             any_req;
  logic [N_REQ-1:0] win_oh;
  logic [IDX_W-1:0] win_idx;

  logic [N_REQ-1:0] gnt_q, gnt_d;
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             load_en;
  logic             ptr_en;

  dprio_level_sel #(
    .N_REQ  (N_REQ),
    .PRIO_W (PRIO_W)
  ) u_level (
    .req_i  (req_i),
    .prio_i (prio_i),
    .cand_o (cand),
    .any_o  (any_req)
  );

  dprio_tie_break #(
    .N_REQ    (N_REQ),
    .TIE_MODE (TIE_MODE)
  ) u_tie (
    .cand_i   (cand),
    .ptr_i    (ptr_q),
    .win_oh_o (win_oh)
  );

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (win_oh[i]) begin
        win_idx = win_idx | IDX_W'(i);
      end
    end
  end

  // Next-state: latch a decision when idle or when the held grant is consumed.
  assign load_en = !vld_q || ack_i;
  assign ptr_en  = load_en && any_req;

  always_comb begin
    gnt_d = gnt_q;
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (load_en) begin
      gnt_d = win_oh;
      vld_d = any_req;
    end
    if (ptr_en) begin
      ptr_d = win_idx;
    end
  end

  // State registers, reset style chosen by parameter.
  if (ASYNC_RST) begin : g_arst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gnt_q <= '0;
        vld_q <= 1'b0;
        ptr_q <= PTR_RST;
      end else begin
        if (load_en) begin
          gnt_q <= gnt_d;
          vld_q <= vld_d;
        end
        if (ptr_en) begin
          ptr_q <= ptr_d;
        end
      end
    end
  end else begin : g_srst
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gnt_q <= '0;
        vld_q <= 1'b0;
        ptr_q <= PTR_RST;
      end else begin
        if (load_en) begin
          gnt_q <= gnt_d;
          vld_q <= vld_d;
        end
        if (ptr_en) begin
          ptr_q <= ptr_d;
        end
      end
    end
  end

  dprio_grant_enc #(
    .N_REQ (N_REQ),
    .FMT   (GRANT_FMT)
  ) u_enc (
    .oh_i   (gnt_q),
    .code_o (grant_o)
  );

  assign valid_o = vld_q;

endmodule

// File: rtl/dprio_arb_chk.sv
module dprio_arb_chk #(
  parameter int N_REQ  = 4,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REQ-1:0]        req_i,
  input logic [N_REQ*PRIO_W-1:0] prio_i,
  input logic                    ack_i,
  input logic                    valid_o,
  input logic [N_REQ-1:0]        gnt_oh,
  input logic [IDX_W-1:0]        ptr
);

  logic [N_REQ-1:0]        req_s;
  logic [N_REQ*PRIO_W-1:0] prio_s;
  logic [PRIO_W-1:0]       win_lvl;
  logic                    outranked;

  always_ff @(posedge clk) begin
    req_s  <= req_i;
    prio_s <= prio_i;
  end

  always_comb begin
    win_lvl = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt_oh[i]) win_lvl = prio_s[i*PRIO_W +: PRIO_W];
    end
    outranked = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_s[i] && (prio_s[i*PRIO_W +: PRIO_W] > win_lvl)) outranked = 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ack_i) |=> ($stable(gnt_oh) && valid_o)); // R6

  AST_PTR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ack_i) |=> $stable(ptr)); // R6

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o || ack_i) |=> (valid_o == $past(|req_i))); // R2

  AST_GRANT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((!valid_o || ack_i) && |req_i) |=> ((gnt_oh & req_s) != '0)); // R3

  AST_GRANT_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((!valid_o || ack_i) && |req_i) |=> !outranked); // R3

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh)); // R8

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (gnt_oh == '0)); // R9

endmodule

bind dprio_arb dprio_arb_chk #(
  .N_REQ  (N_REQ),
  .PRIO_W (PRIO_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .prio_i  (prio_i),
  .ack_i   (ack_i),
  .valid_o (valid_o),
  .gnt_oh  (gnt_q),
  .ptr     (ptr_q)
);

// File: tb/dprio_arb_tb.sv
module dprio_arb_tb;

  localparam int N  = 4;
  localparam int PW = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N*PW-1:0] prio;
  logic         ack;

  logic [N-1:0] g_rot;  logic v_rot;
  logic [1:0]   g_fix;  logic v_fix;
  logic [N-1:0] g_thr;  logic v_thr;

  int n_chk  = 0;
  int n_fail = 0;

  // model state
  logic m_vld;
  int   m_rot;
  int   m_fix;
  int   m_ptr;

  always #10 clk = ~clk;

  dprio_arb #(.N_REQ(N), .PRIO_W(PW), .TIE_MODE(dprio_pkg::TIE_ROTATE),
              .GRANT_FMT(dprio_pkg::GRANT_ONEHOT), .ASYNC_RST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .ack_i(ack),
    .grant_o(g_rot), .valid_o(v_rot));

  dprio_arb #(.N_REQ(N), .PRIO_W(PW), .TIE_MODE(dprio_pkg::TIE_LOWEST_ID),
              .GRANT_FMT(dprio_pkg::GRANT_BINARY), .ASYNC_RST(1'b0)) u_fix (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .ack_i(ack),
    .grant_o(g_fix), .valid_o(v_fix));

  dprio_arb #(.N_REQ(N), .PRIO_W(PW), .TIE_MODE(dprio_pkg::TIE_ROTATE),
              .GRANT_FMT(dprio_pkg::GRANT_THERMO), .ASYNC_RST(1'b1)) u_thr (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .ack_i(ack),
    .grant_o(g_thr), .valid_o(v_thr));

  function automatic int pick(input logic [N-1:0] r, input logic [N*PW-1:0] p,
                              input int ptr, input bit rotate);
    int top;
    int start;
    top = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && int'(p[i*PW +: PW]) > top) top = int'(p[i*PW +: PW]);
    if (top < 0) return -1;
    start = rotate ? (ptr + 1) % N : 0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (start + k) % N;
      if (r[j] && int'(p[j*PW +: PW]) == top) return j;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int e_oh, e_bin, e_th;
    e_oh  = m_vld ? (1 << m_rot) : 0;
    e_th  = m_vld ? ((2 << m_rot) - 1) : 0;
    e_bin = m_vld ? m_fix : 0;
    check(tag, "rotate valid", int'(v_rot), int'(m_vld));
    check(tag, "rotate onehot grant", int'(g_rot), e_oh);
    check(tag, "fixed valid", int'(v_fix), int'(m_vld));
    check(tag, "fixed binary grant", int'(g_fix), e_bin);
    check(tag, "thermo valid", int'(v_thr), int'(m_vld));
    check(tag, "thermo grant", int'(g_thr), e_th);
  endtask

  // one clock: update model from the inputs at the coming edge, then compare
  task automatic step(input string tag);
    if (!m_vld || ack) begin
      m_vld = |req;
      if (|req) begin
        m_rot = pick(req, prio, m_ptr, 1'b1);
        m_fix = pick(req, prio, 0, 1'b0);
        m_ptr = m_rot;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_vld = 1'b0; m_ptr = N - 1; m_rot = 0; m_fix = 0;
    check_all("R1 R10 in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; req = '0; prio = '0; ack = 1'b0;
    m_vld = 1'b0; m_ptr = N - 1; m_rot = 0; m_fix = 0;
    @(negedge clk);
    do_reset();
    step("R1 first cycle after reset");

    // R1: first rotating search starts at index 0
    req = 4'b1111; prio = 8'h00; ack = 1'b1;
    step("R1 first grant index 0");

    // R5: rotation through equal requestors, wrap
    for (int k = 0; k < 6; k++) step("R5 rotation wrap");

    // R3 R4 R5 R7 R8: exhaustive sweep, ack held high, priorities change every cycle
    for (int r = 0; r < 16; r++) begin
      for (int p = 0; p < 256; p++) begin
        req = r[3:0]; prio = p[7:0];
        step("R3 R4 R5 R7 R8 sweep");
      end
    end

    // R9: no request
    req = '0;
    step("R9 idle");
    step("R9 idle hold");

    // R2: ack low while idle still latches
    ack = 1'b0; req = 4'b0100; prio = 8'h10;
    step("R2 latch while idle");

    // R6: stall, inputs moving, nothing changes
    for (int k = 0; k < 12; k++) begin
      req = 4'(k * 5 + 3); prio = 8'(k * 37);
      step("R6 stall hold");
    end
    req = '0;
    step("R6 stall with no request");

    // R7: runtime priority change applied at next consume
    req = 4'b1111; prio = 8'b11_00_00_00; ack = 1'b1;
    step("R7 priority change");
    prio = 8'b00_00_00_11;
    step("R7 priority change again");
    prio = 8'b00_10_10_00;
    step("R7 tie at middle level");
    step("R5 R7 tie rotates");

    // R1 R10: reset in mid-run clears pointer
    req = 4'b1111; prio = 8'h55; ack = 1'b0;
    do_reset();
    step("R1 R10 after mid-run reset");
    ack = 1'b1;
    step("R1 R10 pointer cleared");
    step("R5 after reset next");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule